// File: doc/BRIEF.md
# Quadrature Position Counter with Bound Checking

This block keeps a 32-bit signed position count driven by two count pins and a third marker pin, as produced by shaft encoders, motor drives or hand-turned thumbwheels. One of four decoding schemes turns the pins into up and down steps. The two pins can be read as a Gray-coded quadrature pair or as a plain 2-bit binary number. The block can instead treat one pin as a count clock and the other as a direction level. In the last scheme, rising edges on the two pins count in opposite directions. Each of the three pins first passes through its own glitch filter, and all three filters share one programmable period.

The marker pin can zero the count, or it can serve only as a push-button event. Each step leaves a one-cycle strobe on `cnt_evt`, so an external timer can measure the time between counts. A low and a high bound are compared with every new count. When a step leaves the count beyond a bound, the block either raises a sticky flag or forces the count back to zero, depending on a control bit. A small register port gives access to the control, filter period, bounds, count and flags. `irq` is high while any flag is set.

Top module: `posctr_top`

## Requirements
- R1: After reset the count is 0, all flags are 0, `cnt_evt` and `irq` are low, control reads 0, the filter period reads 0, the low bound reads 0x80000000 and the high bound reads 0x7FFFFFFF.
- R2: With control bits [1:0]=0 (quadrature), the pin pair {a,b} stepping 00→01→11→10→00 counts up by one per transition, and the reverse order counts down by one.
- R3: In quadrature mode, a transition in which both pins change together leaves the count unchanged and sets status bit 2. The bit stays set until it is cleared.
- R4: With control bits [1:0]=1 (binary), {a,b} is read as an unsigned 2-bit number. A change of +1 modulo 4 counts up, a change of −1 counts down, and a change of 2 sets status bit 2 without counting.
- R5: With control bits [1:0]=2 (direction pin), each rising edge of a counts up when b is 0 and down when b is 1. Changes of b alone, and falling edges of a, do not count.
- R6: With control bits [1:0]=3 (dual edge), a rising edge of a counts up and a rising edge of b counts down. Falling edges do not count, and rising edges on both pins in the same cycle cancel.
- R7: A pin level reaches the decoder only after it has differed from the accepted level for N consecutive cycles, where N is the period register (address 1). Shorter pulses are ignored, and N=0 passes a one-cycle pulse.
- R8: A rising edge of the filtered marker pin sets status bit 3. When control bit 3 is set, the same edge also zeroes the count.
- R9: With control bit 2 clear, an up step that leaves the count (signed) above the high bound (address 3) sets status bit 0. A down step that leaves it below the low bound (address 2) sets status bit 1.
- R10: With control bit 2 set, a step that would go past either bound loads 0 into the count instead, and no bound flag is set.
- R11: Each counted step raises `cnt_evt` for exactly one cycle, and the count does not change without a step, a marker clear or a count write.
- R12: The count wraps modulo 2^32, and a write to address 4 loads the count directly.
- R13: Writing 1 to a bit of the status register (address 5) clears that bit, and writing 0 leaves it unchanged. `irq` is high exactly when a status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | First count pin |
| pin_b | input | 1 | Second count pin (direction level in direction-pin mode) |
| pin_z | input | 1 | Marker / push-button pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 period, 2 low, 3 high, 4 count, 5 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| cnt_evt | output | 1 | One-cycle strobe per counted step |
| irq | output | 1 | High while any status flag is set |

## Verification
The pin is sampled on clock edge 1. The filtered level changes on edge 1+max(N,1), and the count, flags and `cnt_evt` are updated on edge 2+max(N,1). Register writes take effect on the edge that ends the write cycle, and the read data follows the address within the same cycle. After each pin change, the bench waits twelve cycles before it samples the read data on a falling edge. This wait is longer than the worst latency for any period it programs. It counts `cnt_evt` pulses on falling edges, so each one-cycle pulse is counted exactly once. The glitch cases are timed in whole cycles against the programmed period.

// File: rtl/posctr_pkg.sv
package posctr_pkg;
    typedef enum logic [1:0] {
        MODE_QUAD = 2'd0,
        MODE_BIN  = 2'd1,
        MODE_DIR  = 2'd2,
        MODE_DUAL = 2'd3
    } cmode_e;

    localparam int          ADDR_W = 3;
    localparam logic [2:0]  A_CTRL = 3'd0;
    localparam logic [2:0]  A_DBN  = 3'd1;
    localparam logic [2:0]  A_LO   = 3'd2;
    localparam logic [2:0]  A_HI   = 3'd3;
    localparam logic [2:0]  A_CNT  = 3'd4;
    localparam logic [2:0]  A_STAT = 3'd5;

    localparam int F_ABOVE = 0;
    localparam int F_BELOW = 1;
    localparam int F_ILL   = 2;
    localparam int F_MARK  = 3;
    localparam int NFLAG   = 4;
endpackage

// File: rtl/posctr_debounce.sv
module posctr_debounce #(
    parameter int DBN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DBN_W-1:0] period,
    input  logic             pin_i,
    output logic             level_o
);
    localparam logic [DBN_W-1:0] ONE = {{(DBN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             raw;
        logic             lvl;
        logic [DBN_W-1:0] run;
    } dbn_st_t;

    dbn_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.raw = pin_i;
        if (st_q.raw == st_q.lvl) begin
            st_d.run = '0;
        end else if (period == '0 || (st_q.run + ONE) >= period) begin
            st_d.lvl = st_q.raw;
            st_d.run = '0;
        end else begin
            st_d.run = st_q.run + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.lvl;
endmodule

// File: rtl/posctr_decode.sv
module posctr_decode
    import posctr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cmode_e mode,
    input  logic   a,
    input  logic   b,
    input  logic   z,
    output logic   step_up,
    output logic   step_dn,
    output logic   step_bad,
    output logic   z_rise
);
    typedef struct packed {
        logic pa;
        logic pb;
        logic pz;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic [1:0] code_new, code_old, diff;
    logic       rise_a, rise_b;

    always_comb begin
        st_d = '{pa: a, pb: b, pz: z};
        if (mode == MODE_QUAD) begin
            code_new = {a, a ^ b};
            code_old = {st_q.pa, st_q.pa ^ st_q.pb};
        end else begin
            code_new = {a, b};
            code_old = {st_q.pa, st_q.pb};
        end
        diff     = code_new - code_old;
        rise_a   = a & ~st_q.pa;
        rise_b   = b & ~st_q.pb;
        step_up  = 1'b0;
        step_dn  = 1'b0;
        step_bad = 1'b0;
        case (mode)
            MODE_QUAD, MODE_BIN: begin
                step_up  = (diff == 2'd1);
                step_dn  = (diff == 2'd3);
                step_bad = (diff == 2'd2);
            end
            MODE_DIR: begin
                step_up = rise_a & ~b;
                step_dn = rise_a & b;
            end
            default: begin
                step_up = rise_a & ~rise_b;
                step_dn = rise_b & ~rise_a;
            end
        endcase
        z_rise = z & ~st_q.pz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/posctr_top.sv
module posctr_top
    import posctr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DBN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_a,
    input  logic                 pin_b,
    input  logic                 pin_z,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [CNT_W-1:0]     reg_wdata,
    output logic [CNT_W-1:0]     reg_rdata,
    output logic                 cnt_evt,
    output logic                 irq
);
    localparam int NPIN = 3;
    localparam logic [CNT_W-1:0] ONE_C  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] S_MIN  = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] S_MAX  = {1'b0, {(CNT_W-1){1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic [DBN_W-1:0] dbn;
        cmode_e           mode;
        logic             az;
        logic             zen;
        logic [NFLAG-1:0] flags;
        logic             evt;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NPIN-1:0] pin_vec, filt;
    logic            dec_up, dec_dn, dec_bad, dec_zr;

    assign pin_vec = {pin_z, pin_b, pin_a};

    for (genvar g = 0; g < NPIN; g++) begin : g_dbn
        posctr_debounce #(.DBN_W(DBN_W)) u_dbn (
            .clk     (clk),
            .rst_n   (rst_n),
            .period  (st_q.dbn),
            .pin_i   (pin_vec[g]),
            .level_o (filt[g])
        );
    end

    posctr_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (st_q.mode),
        .a        (filt[0]),
        .b        (filt[1]),
        .z        (filt[2]),
        .step_up  (dec_up),
        .step_dn  (dec_dn),
        .step_bad (dec_bad),
        .z_rise   (dec_zr)
    );

    logic [CNT_W-1:0] nxt;
    logic [NFLAG-1:0] fset, fclr;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        fset     = '0;
        fclr     = '0;
        nxt      = st_q.count;

        if (dec_up) begin
            nxt      = st_q.count + ONE_C;
            st_d.evt = 1'b1;
            if ($signed(nxt) > $signed(st_q.hi)) begin
                if (st_q.az) nxt = '0;
                else         fset[F_ABOVE] = 1'b1;
            end
        end else if (dec_dn) begin
            nxt      = st_q.count - ONE_C;
            st_d.evt = 1'b1;
            if ($signed(nxt) < $signed(st_q.lo)) begin
                if (st_q.az) nxt = '0;
                else         fset[F_BELOW] = 1'b1;
            end
        end

        if (dec_bad) fset[F_ILL] = 1'b1;
        if (dec_zr) begin
            fset[F_MARK] = 1'b1;
            if (st_q.zen) nxt = '0;
        end
        st_d.count = nxt;

        if (reg_we) begin
            case (reg_addr)
                A_CTRL: begin
                    st_d.mode = cmode_e'(reg_wdata[1:0]);
                    st_d.az   = reg_wdata[2];
                    st_d.zen  = reg_wdata[3];
                end
                A_DBN:  st_d.dbn   = reg_wdata[DBN_W-1:0];
                A_LO:   st_d.lo    = reg_wdata;
                A_HI:   st_d.hi    = reg_wdata;
                A_CNT:  st_d.count = reg_wdata;
                A_STAT: fclr       = reg_wdata[NFLAG-1:0];
                default: ;
            endcase
        end
        st_d.flags = (st_q.flags & ~fclr) | fset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.lo    <= S_MIN;
            st_q.hi    <= S_MAX;
            st_q.mode  <= MODE_QUAD;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL: reg_rdata = {{(CNT_W-4){1'b0}}, st_q.zen, st_q.az, st_q.mode};
            A_DBN:  reg_rdata = {{(CNT_W-DBN_W){1'b0}}, st_q.dbn};
            A_LO:   reg_rdata = st_q.lo;
            A_HI:   reg_rdata = st_q.hi;
            A_CNT:  reg_rdata = st_q.count;
            A_STAT: reg_rdata = {{(CNT_W-NFLAG){1'b0}}, st_q.flags};
            default: reg_rdata = '0;
        endcase
    end

    assign cnt_evt = st_q.evt;
    assign irq     = |st_q.flags;

    logic [CNT_W-1:0] count_q;
    logic [NFLAG-1:0] flags_q;
    logic             cnt_wr, zclr, ill_clr, az_q;
    assign count_q = st_q.count;
    assign flags_q = st_q.flags;
    assign cnt_wr  = reg_we && (reg_addr == A_CNT);
    assign zclr    = dec_zr && st_q.zen;
    assign ill_clr = reg_we && (reg_addr == A_STAT) && reg_wdata[F_ILL];
    assign az_q    = st_q.az;
endmodule

// File: rtl/posctr_chk.sv
module posctr_chk
    import posctr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_q,
    input logic [NFLAG-1:0] flags_q,
    input logic             cnt_evt,
    input logic             cnt_wr,
    input logic             zclr,
    input logic             ill_clr,
    input logic             az_q,
    input logic             dec_up,
    input logic             dec_dn
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count_q == '0 && flags_q == '0 && !cnt_evt));

    // R11
    count_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != $past(count_q)) |-> (cnt_evt || $past(cnt_wr) || $past(zclr)));

    // R2
    single_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_up && dec_dn));

    // R3
    ill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flags_q[F_ILL]) && !$past(ill_clr)) |-> flags_q[F_ILL]);

    // R9
    above_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[F_ABOVE]) |-> ($past(dec_up) && !$past(az_q)));

    // R11
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_evt |-> ($past(dec_up) || $past(dec_dn)));
endmodule

bind posctr_top posctr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_q (count_q),
    .flags_q (flags_q),
    .cnt_evt (cnt_evt),
    .cnt_wr  (cnt_wr),
    .zclr    (zclr),
    .ill_clr (ill_clr),
    .az_q    (az_q),
    .dec_up  (dec_up),
    .dec_dn  (dec_dn)
);

// File: tb/posctr_top_tb.sv
module posctr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_a = 1'b0, pin_b = 1'b0, pin_z = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cnt_evt, irq;

    int tests = 0, fails = 0, evt_n = 0;
    bit done = 0;

    always #4 clk = ~clk;

    posctr_top u_dut (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_z(pin_z),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cnt_evt(cnt_evt), .irq(irq)
    );

    always @(negedge clk) if (cnt_evt) evt_n++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic settle;
        repeat (12) @(negedge clk);
    endtask

    task automatic pins(input logic a, input logic b, input logic z);
        @(negedge clk); pin_a = a; pin_b = b; pin_z = z;
        settle();
    endtask

    function automatic logic [1:0] gray(input logic [1:0] i);
        case (i)
            2'd0: gray = 2'b00;
            2'd1: gray = 2'b01;
            2'd2: gray = 2'b11;
            default: gray = 2'b10;
        endcase
    endfunction

    function automatic logic [31:0] step(input logic [31:0] c, input int d);
        step = c + 32'(d);
    endfunction

    logic [31:0] v, model;
    logic [1:0]  qi;
    int          e0;
    bit          saw_bad;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd4, v); chk("R1 count", v, 0);
        rd(3'd5, v); chk("R1 status", v, 0);
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd1, v); chk("R1 period", v, 0);
        rd(3'd2, v); chk("R1 low", v, 32'h80000000);
        rd(3'd3, v); chk("R1 high", v, 32'h7FFFFFFF);
        chk("R1 evt/irq", {30'd0, cnt_evt, irq}, 0);

        wr(3'd1, 2);
        // R2 quadrature up/down
        qi = 0; e0 = evt_n;
        for (int k = 0; k < 4; k++) begin qi = qi + 1; pins(gray(qi)[1], gray(qi)[0], 0); end
        rd(3'd4, v); chk("R2 up four", v, 4);
        chk("R11 strobes per step", 32'(evt_n - e0), 4);
        for (int k = 0; k < 2; k++) begin qi = qi - 1; pins(gray(qi)[1], gray(qi)[0], 0); end
        rd(3'd4, v); chk("R2 down two", v, 2);

        // R3 illegal jump
        qi = qi + 2; pins(gray(qi)[1], gray(qi)[0], 0);
        rd(3'd4, v); chk("R3 count kept", v, 2);
        rd(3'd5, v); chk("R3 err flag", v, 4);
        chk("R13 irq set", {31'd0, irq}, 1);
        wr(3'd5, 0);
        rd(3'd5, v); chk("R13 write 0 keeps", v, 4);
        wr(3'd5, 4);
        rd(3'd5, v); chk("R13 w1c clears", v, 0);
        chk("R13 irq low", {31'd0, irq}, 0);

        // R2/R3 constrained random quadrature walk
        void'($urandom(32'd2024));
        model = 2; saw_bad = 0;
        for (int k = 0; k < 300; k++) begin
            int r;
            r = $urandom % 16;
            if (r == 0) begin qi = qi + 2; saw_bad = 1; end
            else if (r < 8) begin qi = qi + 1; model = step(model, 1); end
            else begin qi = qi - 1; model = step(model, -1); end
            pins(gray(qi)[1], gray(qi)[0], 0);
        end
        rd(3'd4, v); chk("R2 random walk count", v, model);
        rd(3'd5, v); chk("R3 random sticky", v, saw_bad ? 32'd4 : 32'd0);
        wr(3'd5, 32'hF);

        // R4 binary
        wr(3'd0, 1);
        qi = {pin_a, pin_b}; model = v; rd(3'd4, model);
        for (int k = 0; k < 3; k++) begin qi = qi + 1; pins(qi[1], qi[0], 0); end
        rd(3'd4, v); chk("R4 binary up", v, step(model, 3));
        qi = qi - 1; pins(qi[1], qi[0], 0);
        rd(3'd4, v); chk("R4 binary down", v, step(model, 2));
        qi = qi + 2; pins(qi[1], qi[0], 0);
        rd(3'd4, v); chk("R4 binary skip no count", v, step(model, 2));
        rd(3'd5, v); chk("R4 binary skip flag", v, 4);
        wr(3'd5, 32'hF);

        // R5 direction pin
        wr(3'd0, 2);
        rd(3'd4, model);
        pins(0, 0, 0); pins(0, 1, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R5 no count on a fall or b", v, model);
        pins(1, 0, 0); pins(0, 0, 0); pins(1, 0, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R5 up with b low", v, step(model, 2));
        pins(0, 1, 0); pins(1, 1, 0); pins(0, 1, 0);
        rd(3'd4, v); chk("R5 down with b high", v, step(model, 1));

        // R6 dual edge
        wr(3'd0, 3);
        pins(0, 0, 0); rd(3'd4, model);
        pins(1, 0, 0);
        rd(3'd4, v); chk("R6 a rise up", v, step(model, 1));
        pins(0, 0, 0);
        rd(3'd4, v); chk("R6 a fall none", v, step(model, 1));
        pins(0, 1, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R6 b rise down", v, model);
        pins(1, 1, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R6 both cancel", v, model);

        // R7 debounce
        wr(3'd1, 6);
        @(negedge clk); pin_a = 1; repeat (3) @(negedge clk); pin_a = 0; settle();
        rd(3'd4, v); chk("R7 short glitch ignored", v, model);
        pins(1, 0, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R7 held level counts", v, step(model, 1));
        wr(3'd1, 0);
        @(negedge clk); pin_a = 1; @(negedge clk); pin_a = 0; settle();
        rd(3'd4, v); chk("R7 bypass one-cycle pulse", v, step(model, 2));
        wr(3'd1, 2);

        // R8 marker
        rd(3'd4, model);
        pins(0, 0, 1); pins(0, 0, 0);
        rd(3'd4, v); chk("R8 marker no clear", v, model);
        rd(3'd5, v); chk("R8 marker flag", v, 8);
        wr(3'd5, 8);
        wr(3'd0, 32'h0B);
        pins(0, 0, 1); pins(0, 0, 0);
        rd(3'd4, v); chk("R8 marker clears", v, 0);
        rd(3'd5, v); chk("R8 marker flag again", v, 8);
        wr(3'd5, 8);

        // R9 bound warnings
        wr(3'd0, 3); wr(3'd3, 3); wr(3'd2, 32'hFFFFFFFE);
        wr(3'd4, 2);
        pins(1, 0, 0); pins(0, 0, 0);
        rd(3'd5, v); chk("R9 at high no flag", v, 0);
        pins(1, 0, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R9 count above", v, 4);
        rd(3'd5, v); chk("R9 above flag", v, 1);
        wr(3'd5, 1);
        wr(3'd4, 32'hFFFFFFFF);
        pins(0, 1, 0); pins(0, 0, 0);
        rd(3'd5, v); chk("R9 at low no flag", v, 0);
        pins(0, 1, 0); pins(0, 0, 0);
        rd(3'd5, v); chk("R9 below flag", v, 2);
        wr(3'd5, 2);

        // R10 auto-zero
        wr(3'd0, 32'h7);
        wr(3'd4, 3);
        pins(1, 0, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R10 high auto-zero", v, 0);
        wr(3'd4, 32'hFFFFFFFE);
        pins(0, 1, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R10 low auto-zero", v, 0);
        rd(3'd5, v); chk("R10 no flags", v, 0);

        // R12 wrap
        wr(3'd0, 3); wr(3'd3, 32'h7FFFFFFF); wr(3'd2, 32'h80000000);
        wr(3'd4, 32'h7FFFFFFF);
        rd(3'd4, v); chk("R12 count write", v, 32'h7FFFFFFF);
        pins(1, 0, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R12 wrap up", v, 32'h80000000);
        pins(0, 1, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R12 wrap back", v, 32'h7FFFFFFF);
        wr(3'd4, 0);
        pins(0, 1, 0); pins(0, 0, 0);
        rd(3'd4, v); chk("R12 zero minus one", v, 32'hFFFFFFFF);
        chk("R11 strobe low at rest", {31'd0, cnt_evt}, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule